// File: doc/BRIEF.md
# Two-Level Vector Instruction Preloader

This block keeps the wide instruction that is about to be issued to a vector unit, and fills its most often changed fields from a table instead of through many narrow register writes. It owns a 512-word, 32-bit configuration RAM. The lower half holds vector definitions: a start address, a bank select and a length. The upper half holds instruction rows: three definition indices and an operation code. A host port fills the RAM. A control processor can still write any field of the instruction buffer directly.

Two commands exist. A single-vector command copies the start address and bank of one definition into one chosen address-generator slot. It does not start anything. An instruction command reads one row and then the three definitions it names, one after the other. It patches the address and bank of address generators 0, 1 and 2, sets the operation code, and then pulses `start` for one cycle. `start` goes high only when the buffer already holds every patch. Step, bounds, flags and vector length are never touched by a command.

Top module: `vec_preloader`

## Requirements
- R1: During and right after reset, `instr` is all zero, `busy` and `start` are low and `cmd_ready` is high.
- R2: A host write (`cfg_we`) stores `cfg_wdata` at `cfg_addr`. Definitions live at `{1'b0, index}` and rows at `{1'b1, index}`. A definition word carries the start address in bits [9:0], the bank in [11:10] and the length in [21:12]. A row word carries the AG2 index in [31:24], the AG1 index in [23:16], the AG0 index in [15:8] and the opcode in [7:0].
- R3: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. When it is taken with `cmd_kind`=0, `busy` is high for exactly the next cycle. After that, slot `cmd_ag` holds the address and bank of definition `cmd_idx`, and `start` stays low throughout. The length is not applied.
- R4: A taken command with `cmd_kind`=1 loads address generators 0, 1 and 2 from the definitions named by the row `cmd_idx`, and loads the row's opcode.
- R5: After an instruction command is taken, `busy` is high for five cycles. `start` is high only in the fifth of these, and the buffer already holds all patches in that cycle. The next cycle shows `busy` low and `start` low.
- R6: Commands change only the address and bank of the slots they load and the opcode. Step, bounds, flags, vector length and all other slots keep their values.
- R7: A direct write (`dw_en`) updates the field of slot `dw_ag` chosen by `dw_field` on the next edge, using the low bits of `dw_data`. This happens whether the block is busy or idle. The encodings are 0 address, 1 bank, 2 step, 3 lower bound, 4 upper bound, 5 flags (4 bits), 6 opcode (8 bits) and 7 vector length.
- R8: On an edge where the preloader writes a slot's address and bank, a direct write to that same slot's address or bank is lost. The same holds for the opcode. A direct write to any other field or slot on that edge still takes effect.
- R9: `cmd_ready` is low from the edge that takes a command until the block is idle again. A command offered during that time is not taken and leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host RAM write enable |
| cfg_addr | input | 9 | Host RAM word address |
| cfg_wdata | input | 32 | Host RAM write data |
| cmd_valid | input | 1 | Command offered |
| cmd_kind | input | 1 | 0 single-vector load, 1 instruction load and start |
| cmd_ag | input | 2 | Target slot for a single-vector command |
| cmd_idx | input | 8 | Definition index or row index |
| cmd_ready | output | 1 | Command can be taken |
| dw_en | input | 1 | Direct buffer write enable |
| dw_ag | input | 2 | Slot of the direct write |
| dw_field | input | 3 | Field selector of the direct write |
| dw_data | input | 10 | Direct write value (low bits used for narrow fields) |
| busy | output | 1 | Command in progress |
| start | output | 1 | One-cycle pulse that issues the patched instruction |
| instr | output | 202 | Instruction buffer: per slot {flags, hi, lo, step, bank, addr} from slot 0 upward, then opcode, then vector length at the top |

## Verification
Two functions can meet on one edge: a direct buffer write from the control processor and a table patch of the same slot. The bench provokes this by issuing a direct write to the address of slot 0 exactly on the edge that loads slot 0 from its definition. On the following edge, which loads slot 1, it issues a direct write to slot 1's step. The first write must be lost, and the slot must show the definition's address. The second must survive next to the freshly patched address and bank. Both results are judged in the cycle `start` is high.

// File: rtl/vpl_pkg.sv
package vpl_pkg;

    localparam int WORD_W  = 32;
    localparam int IDX_W   = 8;
    localparam int RAM_AW  = IDX_W + 1;
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int VADDR_W = 10;
    localparam int BANK_W  = 2;
    localparam int VLEN_W  = 10;
    localparam int STEP_W  = 10;
    localparam int BND_W   = 10;
    localparam int FLAG_W  = 4;
    localparam int OP_W    = 8;
    localparam int DW_W    = 10;
    localparam int SPARE_W = WORD_W - VLEN_W - BANK_W - VADDR_W;

    typedef struct packed {
        logic [SPARE_W-1:0] spare;
        logic [VLEN_W-1:0]  len;
        logic [BANK_W-1:0]  bank;
        logic [VADDR_W-1:0] addr;
    } vdef_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx_ag2;
        logic [IDX_W-1:0] idx_ag1;
        logic [IDX_W-1:0] idx_ag0;
        logic [OP_W-1:0]  opcode;
    } vrow_t;

    typedef struct packed {
        logic [FLAG_W-1:0]  flags;
        logic [BND_W-1:0]   hi_bnd;
        logic [BND_W-1:0]   lo_bnd;
        logic [STEP_W-1:0]  step;
        logic [BANK_W-1:0]  bank;
        logic [VADDR_W-1:0] addr;
    } ag_cfg_t;

    localparam int AG_CFG_W = $bits(ag_cfg_t);

    typedef enum logic [2:0] {
        FLD_ADDR  = 3'd0,
        FLD_BANK  = 3'd1,
        FLD_STEP  = 3'd2,
        FLD_LO    = 3'd3,
        FLD_HI    = 3'd4,
        FLD_FLAGS = 3'd5,
        FLD_OP    = 3'd6,
        FLD_VLEN  = 3'd7
    } field_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_DEF0,
        ST_DEF1,
        ST_DEF2,
        ST_START,
        ST_L1
    } seq_state_e;

    function automatic logic [RAM_AW-1:0] def_word(input logic [IDX_W-1:0] i);
        return {1'b0, i};
    endfunction

    function automatic logic [RAM_AW-1:0] row_word(input logic [IDX_W-1:0] i);
        return {1'b1, i};
    endfunction

endpackage

// File: rtl/vpl_cfg_ram.sv
module vpl_cfg_ram #(
    parameter int DEPTH = 512,
    parameter int AW    = 9,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    // read returns the word held before a same-edge write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/vpl_seq.sv
module vpl_seq
    import vpl_pkg::*;
#(
    parameter int NUM_AG = 4,
    parameter int AG_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_kind,
    input  logic [AG_W-1:0]    cmd_ag,
    input  logic [IDX_W-1:0]   cmd_idx,
    output logic               cmd_ready,
    output logic               busy,
    output logic               start,
    output logic [RAM_AW-1:0]  rd_addr,
    input  logic [WORD_W-1:0]  rd_data,
    output logic               ld_en,
    output logic [AG_W-1:0]    ld_ag,
    output logic [VADDR_W-1:0] ld_addr,
    output logic [BANK_W-1:0]  ld_bank,
    output logic               op_en,
    output logic [OP_W-1:0]    op_val
);
    seq_state_e       st;
    logic [IDX_W-1:0] idx1_q, idx2_q;
    logic [OP_W-1:0]  op_q;
    logic [AG_W-1:0]  l1_ag_q;
    vrow_t            row_now;
    vdef_t            def_now;

    assign row_now = vrow_t'(rd_data);
    assign def_now = vdef_t'(rd_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            idx1_q  <= '0;
            idx2_q  <= '0;
            op_q    <= '0;
            l1_ag_q <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_kind) begin
                            st <= ST_ROW;
                        end else begin
                            st      <= ST_L1;
                            l1_ag_q <= cmd_ag;
                        end
                    end
                end
                ST_ROW: begin
                    idx1_q <= row_now.idx_ag1;
                    idx2_q <= row_now.idx_ag2;
                    op_q   <= row_now.opcode;
                    st     <= ST_DEF0;
                end
                ST_DEF0:  st <= ST_DEF1;
                ST_DEF1:  st <= ST_DEF2;
                ST_DEF2:  st <= ST_START;
                ST_START: st <= ST_IDLE;
                ST_L1:    st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_ready = (st == ST_IDLE);
        busy      = (st != ST_IDLE);
        start     = (st == ST_START);
        unique case (st)
            ST_IDLE: rd_addr = cmd_kind ? row_word(cmd_idx) : def_word(cmd_idx);
            ST_ROW:  rd_addr = def_word(row_now.idx_ag0);
            ST_DEF0: rd_addr = def_word(idx1_q);
            ST_DEF1: rd_addr = def_word(idx2_q);
            default: rd_addr = '0;
        endcase
        ld_en = 1'b1;
        unique case (st)
            ST_DEF0: ld_ag = AG_W'(0);
            ST_DEF1: ld_ag = AG_W'(1);
            ST_DEF2: ld_ag = AG_W'(2);
            ST_L1:   ld_ag = l1_ag_q;
            default: begin
                ld_ag = '0;
                ld_en = 1'b0;
            end
        endcase
        ld_addr = def_now.addr;
        ld_bank = def_now.bank;
        op_en   = (st == ST_DEF2);
        op_val  = op_q;
    end
endmodule

// File: rtl/vpl_buffer.sv
module vpl_buffer
    import vpl_pkg::*;
#(
    parameter int NUM_AG = 4,
    parameter int AG_W   = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   dw_en,
    input  logic [AG_W-1:0]        dw_ag,
    input  field_e                 dw_field,
    input  logic [DW_W-1:0]        dw_data,
    input  logic                   ld_en,
    input  logic [AG_W-1:0]        ld_ag,
    input  logic [VADDR_W-1:0]     ld_addr,
    input  logic [BANK_W-1:0]      ld_bank,
    input  logic                   op_en,
    input  logic [OP_W-1:0]        op_val,
    output ag_cfg_t [NUM_AG-1:0]   ags_o,
    output logic [OP_W-1:0]        opcode_o,
    output logic [VLEN_W-1:0]      vlen_o
);
    for (genvar g = 0; g < NUM_AG; g++) begin : g_slot
        ag_cfg_t cfg_q;
        logic    dw_hit, ld_hit;

        assign dw_hit = dw_en && (dw_ag == AG_W'(g));
        assign ld_hit = ld_en && (ld_ag == AG_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q <= '0;
            end else begin
                // table patch outranks a direct write to the same fields
                if (ld_hit) begin
                    cfg_q.addr <= ld_addr;
                    cfg_q.bank <= ld_bank;
                end else if (dw_hit && dw_field == FLD_ADDR) begin
                    cfg_q.addr <= dw_data[VADDR_W-1:0];
                end else if (dw_hit && dw_field == FLD_BANK) begin
                    cfg_q.bank <= dw_data[BANK_W-1:0];
                end
                if (dw_hit) begin
                    unique case (dw_field)
                        FLD_STEP:  cfg_q.step   <= dw_data[STEP_W-1:0];
                        FLD_LO:    cfg_q.lo_bnd <= dw_data[BND_W-1:0];
                        FLD_HI:    cfg_q.hi_bnd <= dw_data[BND_W-1:0];
                        FLD_FLAGS: cfg_q.flags  <= dw_data[FLAG_W-1:0];
                        default: ;
                    endcase
                end
            end
        end

        assign ags_o[g] = cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode_o <= '0;
            vlen_o   <= '0;
        end else begin
            if (op_en) begin
                opcode_o <= op_val;
            end else if (dw_en && dw_field == FLD_OP) begin
                opcode_o <= dw_data[OP_W-1:0];
            end
            if (dw_en && dw_field == FLD_VLEN) begin
                vlen_o <= dw_data[VLEN_W-1:0];
            end
        end
    end
endmodule

// File: rtl/vec_preloader.sv
module vec_preloader
    import vpl_pkg::*;
#(
    parameter  int NUM_AG  = 4,
    localparam int AG_W    = (NUM_AG > 1) ? $clog2(NUM_AG) : 1,
    localparam int INSTR_W = NUM_AG * AG_CFG_W + OP_W + VLEN_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [RAM_AW-1:0]  cfg_addr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    input  logic               cmd_valid,
    input  logic               cmd_kind,
    input  logic [AG_W-1:0]    cmd_ag,
    input  logic [IDX_W-1:0]   cmd_idx,
    output logic               cmd_ready,
    input  logic               dw_en,
    input  logic [AG_W-1:0]    dw_ag,
    input  logic [2:0]         dw_field,
    input  logic [DW_W-1:0]    dw_data,
    output logic               busy,
    output logic               start,
    output logic [INSTR_W-1:0] instr
);
    logic [RAM_AW-1:0]    rd_addr;
    logic [WORD_W-1:0]    rd_data;
    logic                 ld_en, op_en;
    logic [AG_W-1:0]      ld_ag;
    logic [VADDR_W-1:0]   ld_addr;
    logic [BANK_W-1:0]    ld_bank;
    logic [OP_W-1:0]      op_val;
    ag_cfg_t [NUM_AG-1:0] ags;
    logic [OP_W-1:0]      opcode;
    logic [VLEN_W-1:0]    vlen;

    vpl_cfg_ram #(
        .DEPTH (RAM_DEPTH),
        .AW    (RAM_AW),
        .DW    (WORD_W)
    ) u_ram (
        .clk   (clk),
        .we    (cfg_we),
        .waddr (cfg_addr),
        .wdata (cfg_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    vpl_seq #(
        .NUM_AG (NUM_AG),
        .AG_W   (AG_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_kind  (cmd_kind),
        .cmd_ag    (cmd_ag),
        .cmd_idx   (cmd_idx),
        .cmd_ready (cmd_ready),
        .busy      (busy),
        .start     (start),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .ld_en     (ld_en),
        .ld_ag     (ld_ag),
        .ld_addr   (ld_addr),
        .ld_bank   (ld_bank),
        .op_en     (op_en),
        .op_val    (op_val)
    );

    vpl_buffer #(
        .NUM_AG (NUM_AG),
        .AG_W   (AG_W)
    ) u_buf (
        .clk      (clk),
        .rst      (rst),
        .dw_en    (dw_en),
        .dw_ag    (dw_ag),
        .dw_field (field_e'(dw_field)),
        .dw_data  (dw_data),
        .ld_en    (ld_en),
        .ld_ag    (ld_ag),
        .ld_addr  (ld_addr),
        .ld_bank  (ld_bank),
        .op_en    (op_en),
        .op_val   (op_val),
        .ags_o    (ags),
        .opcode_o (opcode),
        .vlen_o   (vlen)
    );

    assign instr = {vlen, opcode, ags};
endmodule

// File: rtl/vpl_checker.sv
module vpl_checker
    import vpl_pkg::*;
#(
    parameter int NUM_AG  = 4,
    parameter int INSTR_W = 202
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               cmd_kind,
    input logic               cmd_ready,
    input logic               dw_en,
    input logic               busy,
    input logic               start,
    input logic [INSTR_W-1:0] instr
);
    localparam int KEEP_LSB = VADDR_W + BANK_W;
    localparam int KEEP_W   = AG_CFG_W - KEEP_LSB;
    localparam int VLEN_LSB = NUM_AG * AG_CFG_W + OP_W;

    logic take;
    assign take = cmd_valid && cmd_ready;

    // R5: instruction command keeps busy for five cycles, start in the fifth
    a_r5_busy_window: assert property (@(posedge clk) disable iff (rst)
        take && cmd_kind |=> busy ##1 busy ##1 busy ##1 busy ##1 (busy && start));

    a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
        start |=> !start && !busy);

    // R3: single-vector command is a one-cycle job with no start
    a_r3_short_no_start: assert property (@(posedge clk) disable iff (rst)
        take && !cmd_kind |=> (busy && !start) ##1 (!busy && !start));

    // R9: no second command taken right after one is taken
    a_r9_refuse_after_take: assert property (@(posedge clk) disable iff (rst)
        take |=> !cmd_ready);

    // R6: without a direct write, step, bounds, flags and length stay put
    for (genvar g = 0; g < NUM_AG; g++) begin : g_keep
        a_r6_fields_kept: assert property (@(posedge clk) disable iff (rst)
            !dw_en |=> $stable(instr[g*AG_CFG_W + KEEP_LSB +: KEEP_W]));
    end

    a_r6_vlen_kept: assert property (@(posedge clk) disable iff (rst)
        !dw_en |=> $stable(instr[VLEN_LSB +: VLEN_W]));
endmodule

bind vec_preloader vpl_checker #(
    .NUM_AG  (NUM_AG),
    .INSTR_W (INSTR_W)
) u_vpl_checker (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_ready (cmd_ready),
    .dw_en     (dw_en),
    .busy      (busy),
    .start     (start),
    .instr     (instr)
);

// File: tb/test_vec_preloader.sv
module test_vec_preloader;
    localparam int NAG = 4;
    localparam int AGW = 46;
    localparam int IW  = NAG * AGW + 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [8:0]    cfg_addr;
    logic [31:0]   cfg_wdata;
    logic          cmd_valid, cmd_kind;
    logic [1:0]    cmd_ag;
    logic [7:0]    cmd_idx;
    logic          cmd_ready;
    logic          dw_en;
    logic [1:0]    dw_ag;
    logic [2:0]    dw_field;
    logic [9:0]    dw_data;
    logic          busy, start;
    logic [IW-1:0] instr;

    int checks = 0;
    int errors = 0;
    logic [31:0]   mem_m [512];
    logic [IW-1:0] exp_i;

    always #5 clk = ~clk;

    vec_preloader #(.NUM_AG(NAG)) i_vec_preloader (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_ag(cmd_ag), .cmd_idx(cmd_idx),
        .cmd_ready(cmd_ready), .dw_en(dw_en), .dw_ag(dw_ag), .dw_field(dw_field),
        .dw_data(dw_data), .busy(busy), .start(start), .instr(instr)
    );

    function automatic int fpos(input int ag, input int f);
        case (f)
            0: return ag * AGW;
            1: return ag * AGW + 10;
            2: return ag * AGW + 12;
            3: return ag * AGW + 22;
            4: return ag * AGW + 32;
            5: return ag * AGW + 42;
            6: return NAG * AGW;
            default: return NAG * AGW + 8;
        endcase
    endfunction

    function automatic int fwid(input int f);
        case (f)
            1: return 2;
            5: return 4;
            6: return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic [IW-1:0] put(input logic [IW-1:0] v, input int ag,
                                          input int f, input logic [9:0] d);
        for (int b = 0; b < fwid(f); b++) v[fpos(ag, f) + b] = d[b];
        return v;
    endfunction

    task automatic chk_vec(input string tag, input logic [IW-1:0] act, input logic [IW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [8:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        mem_m[a] = d;
    endtask

    task automatic direct(input logic [1:0] ag, input logic [2:0] f, input logic [9:0] d);
        dw_en = 1'b1; dw_ag = ag; dw_field = f; dw_data = d;
        @(negedge clk);
        dw_en = 1'b0;
        if (f >= 3'd6) exp_i = put(exp_i, 0, int'(f), d);
        else exp_i = put(exp_i, int'(ag), int'(f), d);
        chk_vec("R7 direct write", instr, exp_i);
    endtask

    task automatic do_l1(input logic [1:0] ag, input logic [7:0] idx);
        logic [31:0] d;
        d = mem_m[{1'b0, idx}];
        cmd_valid = 1'b1; cmd_kind = 1'b0; cmd_ag = ag; cmd_idx = idx;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk_bit("R3 busy one cycle", busy, 1'b1);
        chk_bit("R3 no start", start, 1'b0);
        chk_vec("R3 not yet patched", instr, exp_i);
        exp_i = put(exp_i, int'(ag), 0, d[9:0]);
        exp_i = put(exp_i, int'(ag), 1, {8'd0, d[11:10]});
        @(negedge clk);
        chk_bit("R3 busy released", busy, 1'b0);
        chk_bit("R3 no start after", start, 1'b0);
        chk_vec("R3 R2 slot loaded", instr, exp_i);
    endtask

    task automatic do_l2(input logic [7:0] row, input bit coll, input bit refuse);
        logic [31:0] r, d;
        logic [7:0]  ix;
        r = mem_m[{1'b1, row}];
        cmd_valid = 1'b1; cmd_kind = 1'b1; cmd_ag = 2'd0; cmd_idx = row;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            if (k > 1) @(negedge clk);
            chk_bit("R5 busy window", busy, 1'b1);
            chk_bit("R5 start timing", start, k == 5);
            if (k == 1 && refuse) begin
                chk_bit("R9 ready low", cmd_ready, 1'b0);
                cmd_valid = 1'b1; cmd_kind = 1'b0; cmd_ag = 2'd3; cmd_idx = 8'h55;
            end
            if (k == 2) begin
                if (refuse) chk_bit("R9 ready still low", cmd_ready, 1'b0);
                cmd_valid = 1'b0;
                if (coll) begin
                    dw_en = 1'b1; dw_ag = 2'd0; dw_field = 3'd0; dw_data = 10'h3c3;
                end
            end
            if (k == 3 && coll) begin
                dw_ag = 2'd1; dw_field = 3'd2; dw_data = 10'h2a5;
                exp_i = put(exp_i, 1, 2, 10'h2a5);
            end
            if (k == 4) dw_en = 1'b0;
            if (k == 5) begin
                for (int s = 0; s < 3; s++) begin
                    ix = r[8*(s+1) +: 8];
                    d  = mem_m[{1'b0, ix}];
                    exp_i = put(exp_i, s, 0, d[9:0]);
                    exp_i = put(exp_i, s, 1, {8'd0, d[11:10]});
                end
                exp_i = put(exp_i, 0, 6, {2'd0, r[7:0]});
                chk_vec(coll ? "R8 R4 patched at start" : "R4 R2 patched at start", instr, exp_i);
            end
        end
        @(negedge clk);
        chk_bit("R5 busy low after", busy, 1'b0);
        chk_bit("R5 start single", start, 1'b0);
        chk_bit("R9 ready again", cmd_ready, 1'b1);
        chk_vec(refuse ? "R9 refused cmd left no trace" : "R6 other fields kept", instr, exp_i);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        cmd_valid = 1'b0; cmd_kind = 1'b0; cmd_ag = '0; cmd_idx = '0;
        dw_en = 1'b0; dw_ag = '0; dw_field = '0; dw_data = '0;
        exp_i = '0;
        repeat (3) @(negedge clk);
        chk_vec("R1 reset instr", instr, '0);
        chk_bit("R1 reset busy", busy, 1'b0);
        chk_bit("R1 reset start", start, 1'b0);
        chk_bit("R1 reset ready", cmd_ready, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk_vec("R1 after reset instr", instr, '0);

        for (int a = 0; a < 512; a++) host_write(9'(a), $urandom);

        // seed non-patched fields so that R6 has something to keep
        for (int g = 0; g < NAG; g++) begin
            for (int f = 2; f <= 5; f++) direct(2'(g), 3'(f), 10'($urandom));
        end
        direct(2'd0, 3'd7, 10'h1f0);

        // directed: single-vector loads incl. the slot no row touches
        do_l1(2'd3, 8'h00);
        do_l1(2'd0, 8'hff);
        // directed: row whose three indices are the same definition
        host_write({1'b1, 8'h10}, 32'h2a2a2a5c);
        do_l2(8'h10, 1'b0, 1'b0);
        // directed: same-edge direct write and table patch
        do_l2(8'h11, 1'b1, 1'b0);
        // directed: command offered while busy
        do_l2(8'h12, 1'b0, 1'b1);
        // directed: redefine a definition, then use it
        host_write({1'b0, 8'h2a}, 32'h003ff7ff);
        do_l1(2'd2, 8'h2a);

        for (int n = 0; n < 80; n++) begin
            case ($urandom % 4)
                0: direct(2'($urandom), 3'($urandom), 10'($urandom));
                1: do_l1(2'($urandom), 8'($urandom));
                2: do_l2(8'($urandom), 1'b0, 1'b0);
                default: host_write(9'($urandom), $urandom);
            endcase
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule